// File: doc/BRIEF.md
# Dual-Reference Adaptive FIR Filter

This block is a sample-rate adaptive noise canceller with two reference channels. A single tap-data memory and a single coefficient memory hold one combined filter of T taps. A split value S chosen with every sample divides them into two FIR sections. Section A holds the most recent S samples of reference A. Section B holds the remaining T-S taps, fed with reference B. Reference B always enters one sample period late.

For each sample the block forms the error as the primary sample minus both section outputs and presents the negated error. It then adapts every coefficient with a leaky, optionally frozen LMS rule. An optional constant-input bias coefficient belongs to section B.

Each sample arrives as one bundle on a valid/ready input: primary, reference A, reference B and split. `in_ready` is high only while the block is idle. It drops on the cycle after a bundle is taken and stays low until the result appears. A host may hold `in_valid` with the next bundle while the block is busy. That bundle is taken on the first edge where `in_ready` is high. The result is a one-cycle `out_valid` strobe with no back-pressure: `out_neg_err` holds its value until the next strobe. All `cfg_*` pins are sampled on the acceptance edge.

Top module: `dra_filter`

## Requirements
- R1: The total tap count T is `cfg_total`. It is the sum of both sections' taps, not that sum minus one. A value below 4 is treated as 4, and 255 is the largest count the 8-bit pin can carry.
- R2: With S = min(`in_split`, T), taps 0..S-1 form section A and taps S..T-1 form section B. Section A is a delay line of reference A, with the newest sample at tap 0. Section B is a delay line with its newest entry at tap S. S=0 leaves section A empty and S>=T leaves section B empty.
- R3: The reference-B value that enters tap S while a sample is processed is the `in_ref_b` accepted with the previous sample, or 0 after reset.
- R4: The error is e = sat16(d - y), where y = (sum over taps of w*x) >> 23 (arithmetic, coefficients with 23 fraction bits). `out_neg_err` is sat16(-e), so it is never 0x8000. It changes only when `out_valid` pulses.
- R5: Before the taps are multiplied, each coefficient is updated with the previous sample's error and its previous tap value: w := sat24(w - leak + (e_prev*x_prev) >> (7 + `cfg_mu_shift`)). This takes place during the same pass, and the updated w is then used for the product.
- R6: With `cfg_freeze`=1 no coefficient, including the bias coefficient, changes.
- R7: With `cfg_leak_en`=1 the leak term is w >> `cfg_leak_shift` (arithmetic). Otherwise the leak term is 0.
- R8: With `cfg_round`=1, 2^22 is added to the sum before the shift by 23. Otherwise the sum is truncated toward minus infinity.
- R9: With `cfg_dc_en`=1 an extra coefficient, kept apart from the tap memory, takes part in section B. Its input is the constant 32767 and it is updated by the rule of R5.
- R10: A bundle is taken on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the following cycle until `out_valid`. `out_valid` lasts one cycle and `in_ready` is high in that cycle, so a held bundle is taken on the next edge.
- R11: `out_valid` is raised at most 48 + N cycles after the acceptance edge, where N = T + 1.
- R12: Synchronous reset clears the tap data, the coefficients, the bias coefficient, the reference-B delay, the stored error and the output register. After reset `out_neg_err`=0, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample bundle valid |
| in_ready | output | 1 | Block idle, bundle will be taken |
| in_primary | input | 16 | Primary (desired) sample, signed |
| in_ref_a | input | 16 | Reference sample for section A, signed |
| in_ref_b | input | 16 | Reference sample for section B, signed |
| in_split | input | 8 | Number of taps in section A |
| cfg_total | input | 8 | Total taps of both sections |
| cfg_dc_en | input | 1 | Enable bias coefficient on section B |
| cfg_round | input | 1 | Round the filter sum instead of truncating |
| cfg_freeze | input | 1 | Hold all coefficients |
| cfg_leak_en | input | 1 | Enable coefficient leakage |
| cfg_leak_shift | input | 4 | Leak factor as a right shift |
| cfg_mu_shift | input | 4 | Step size as an extra right shift |
| out_valid | output | 1 | One-cycle strobe, new result present |
| out_neg_err | output | 16 | Negated, saturated error, signed |

## Verification
A wrong tap entry or coefficient changes `out_neg_err` on the very next strobe. A corruption in the coefficient path keeps spreading through the error feedback, so every later result also departs from an independent model of the same arithmetic. A misplaced split, or a missing reference-B delay, shows within the first few samples because section B sees the wrong history. A stuck sequencer shows as `in_ready` staying low past 48 + N cycles or as a strobe lasting more than one cycle.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAPS,
    ST_BIAS,
    ST_DONE
  } phase_t;

  // Two's-complement saturation of a wide value to w bits.
  function automatic logic signed [63:0] clamp_s(input logic signed [63:0] v,
                                                 input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/dra_mem.sv
module dra_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wdata;
    end
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/dra_lms_cell.sv
module dra_lms_cell
  import dra_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 24,
  parameter int ACC_W  = 48,
  parameter int SH_W   = 4
) (
  input  logic signed [COEF_W-1:0] w_old,
  input  logic signed [DATA_W-1:0] x_old,
  input  logic signed [DATA_W-1:0] x_new,
  input  logic signed [DATA_W-1:0] err,
  input  logic        [SH_W-1:0]   mu_shift,
  input  logic                     leak_en,
  input  logic        [SH_W-1:0]   leak_shift,
  input  logic                     freeze,
  output logic signed [COEF_W-1:0] w_new,
  output logic signed [ACC_W-1:0]  prod
);

  // Scale from error*data product to coefficient fraction bits.
  localparam int UPD = 2 * (DATA_W - 1) - (COEF_W - 1);

  logic signed [63:0] grad;
  logic signed [63:0] step;
  logic signed [63:0] wide_w;
  logic signed [63:0] leak;
  logic signed [63:0] next_w;
  logic signed [63:0] full_prod;

  always_comb begin
    grad   = 64'(err) * 64'(x_old);
    step   = grad >>> (UPD + int'(mu_shift));
    wide_w = 64'(w_old);
    leak   = leak_en ? (wide_w >>> leak_shift) : 64'sd0;
    next_w = wide_w - leak + step;
    w_new  = freeze ? w_old : COEF_W'(clamp_s(next_w, COEF_W));
    full_prod = 64'(w_new) * 64'(x_new);
    prod   = ACC_W'(full_prod);
  end

endmodule

// File: rtl/dra_seq.sv
module dra_seq
  import dra_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] taps,
  input  logic             bias_en,
  output phase_t           phase,
  output logic [CNT_W-1:0] idx,
  output logic             idle
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (start) begin
            phase <= ST_TAPS;
            idx   <= '0;
          end
        end
        ST_TAPS: begin
          if (idx == taps - CNT_W'(1)) begin
            phase <= bias_en ? ST_BIAS : ST_DONE;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        ST_BIAS: phase <= ST_DONE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign idle = (phase == ST_IDLE);

endmodule

// File: rtl/dra_filter.sv
module dra_filter
  import dra_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 24,
  parameter int TAP_MAX = 256,
  parameter int SH_W    = 4,
  localparam int CNT_W  = $clog2(TAP_MAX)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_primary,
  input  logic signed [DATA_W-1:0] in_ref_a,
  input  logic signed [DATA_W-1:0] in_ref_b,
  input  logic        [CNT_W-1:0]  in_split,
  input  logic        [CNT_W-1:0]  cfg_total,
  input  logic                     cfg_dc_en,
  input  logic                     cfg_round,
  input  logic                     cfg_freeze,
  input  logic                     cfg_leak_en,
  input  logic        [SH_W-1:0]   cfg_leak_shift,
  input  logic        [SH_W-1:0]   cfg_mu_shift,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_neg_err
);

  localparam int ACC_W    = DATA_W + COEF_W + CNT_W;
  localparam int FRAC     = COEF_W - 1;
  localparam int MIN_TAPS = 4;
  localparam logic signed [DATA_W-1:0] BIAS_IN = {1'b0, {(DATA_W-1){1'b1}}};

  phase_t            phase;
  logic [CNT_W-1:0]  idx;
  logic              accept;
  logic [CNT_W-1:0]  taps_c;
  logic [CNT_W-1:0]  split_c;

  // per-sample captured settings
  logic [CNT_W-1:0]  taps_q;
  logic [CNT_W-1:0]  split_q;
  logic              bias_q;
  logic              rnd_q;
  logic              frz_q;
  logic              leak_q;
  logic [SH_W-1:0]   lsh_q;
  logic [SH_W-1:0]   msh_q;

  logic signed [DATA_W-1:0] d_q;
  logic signed [DATA_W-1:0] a_q;
  logic signed [DATA_W-1:0] b_cur_q;
  logic signed [DATA_W-1:0] b_hold_q;
  logic signed [DATA_W-1:0] carry_q;
  logic signed [DATA_W-1:0] err_q;
  logic signed [DATA_W-1:0] out_q;
  logic                     out_vld_q;
  logic signed [COEF_W-1:0] bias_w_q;
  logic signed [ACC_W-1:0]  acc_q;

  logic signed [DATA_W-1:0] x_rd;
  logic signed [COEF_W-1:0] w_rd;
  logic signed [DATA_W-1:0] x_shift_in;
  logic signed [DATA_W-1:0] cell_x_old;
  logic signed [DATA_W-1:0] cell_x_new;
  logic signed [COEF_W-1:0] cell_w_old;
  logic signed [COEF_W-1:0] w_upd;
  logic signed [ACC_W-1:0]  prod;
  logic                     mem_we;
  logic                     in_bias;

  logic signed [ACC_W-1:0]  rnd_add;
  logic signed [ACC_W-1:0]  acc_rnd;
  logic signed [ACC_W-1:0]  y_s;
  logic signed [63:0]       e_wide;
  logic signed [63:0]       e_sat;
  logic signed [63:0]       n_sat;

  assign accept  = in_valid && in_ready;
  assign taps_c  = (cfg_total < CNT_W'(MIN_TAPS)) ? CNT_W'(MIN_TAPS) : cfg_total;
  assign split_c = (in_split > taps_c) ? taps_c : in_split;

  dra_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .taps    (taps_q),
    .bias_en (bias_q),
    .phase   (phase),
    .idx     (idx),
    .idle    (in_ready)
  );

  // Shared delay line: section B's head at the split point, section A's at 0.
  assign x_shift_in = (idx == split_q) ? b_cur_q :
                      (idx == '0)      ? a_q     : carry_q;

  assign mem_we     = (phase == ST_TAPS);
  assign in_bias    = (phase == ST_BIAS);
  assign cell_w_old = in_bias ? bias_w_q : w_rd;
  assign cell_x_old = in_bias ? BIAS_IN  : x_rd;
  assign cell_x_new = in_bias ? BIAS_IN  : x_shift_in;

  dra_mem #(.W(DATA_W), .DEPTH(TAP_MAX)) u_xmem (
    .clk   (clk),
    .rst   (rst),
    .idx   (idx),
    .we    (mem_we),
    .wdata (x_shift_in),
    .rdata (x_rd)
  );

  dra_mem #(.W(COEF_W), .DEPTH(TAP_MAX)) u_wmem (
    .clk   (clk),
    .rst   (rst),
    .idx   (idx),
    .we    (mem_we),
    .wdata (w_upd),
    .rdata (w_rd)
  );

  dra_lms_cell #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .SH_W   (SH_W)
  ) u_cell (
    .w_old      (cell_w_old),
    .x_old      (cell_x_old),
    .x_new      (cell_x_new),
    .err        (err_q),
    .mu_shift   (msh_q),
    .leak_en    (leak_q),
    .leak_shift (lsh_q),
    .freeze     (frz_q),
    .w_new      (w_upd),
    .prod       (prod)
  );

  // Error formation at the end of the pass.
  always_comb begin
    rnd_add = '0;
    if (rnd_q) rnd_add[FRAC-1] = 1'b1;
    acc_rnd = acc_q + rnd_add;
    y_s     = acc_rnd >>> FRAC;
    e_wide  = 64'(d_q) - 64'(y_s);
    e_sat   = clamp_s(e_wide, DATA_W);
    n_sat   = clamp_s(-e_sat, DATA_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q    <= CNT_W'(MIN_TAPS);
      split_q   <= '0;
      bias_q    <= 1'b0;
      rnd_q     <= 1'b0;
      frz_q     <= 1'b0;
      leak_q    <= 1'b0;
      lsh_q     <= '0;
      msh_q     <= '0;
      d_q       <= '0;
      a_q       <= '0;
      b_cur_q   <= '0;
      b_hold_q  <= '0;
      carry_q   <= '0;
      err_q     <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      bias_w_q  <= '0;
      acc_q     <= '0;
    end else begin
      out_vld_q <= (phase == ST_DONE);
      if (accept) begin
        taps_q   <= taps_c;
        split_q  <= split_c;
        bias_q   <= cfg_dc_en;
        rnd_q    <= cfg_round;
        frz_q    <= cfg_freeze;
        leak_q   <= cfg_leak_en;
        lsh_q    <= cfg_leak_shift;
        msh_q    <= cfg_mu_shift;
        d_q      <= in_primary;
        a_q      <= in_ref_a;
        b_cur_q  <= b_hold_q;
        b_hold_q <= in_ref_b;
        acc_q    <= '0;
      end
      case (phase)
        ST_TAPS: begin
          carry_q <= x_rd;
          acc_q   <= acc_q + prod;
        end
        ST_BIAS: begin
          bias_w_q <= w_upd;
          acc_q    <= acc_q + prod;
        end
        ST_DONE: begin
          err_q <= DATA_W'(e_sat);
          out_q <= DATA_W'(n_sat);
        end
        default: ;
      endcase
    end
  end

  assign out_valid   = out_vld_q;
  assign out_neg_err = out_q;

endmodule

// File: rtl/dra_filter_chk.sv
module dra_filter_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CNT_W-1:0]  cfg_total,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_neg_err
);

  localparam int BW = CNT_W + 2;

  logic          armed;
  logic [BW-1:0] busy_cnt;
  logic [BW-1:0] bound_q;
  logic [CNT_W-1:0] taps_eff;

  assign taps_eff = (cfg_total < CNT_W'(4)) ? CNT_W'(4) : cfg_total;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      busy_cnt <= '0;
      bound_q  <= '0;
    end else begin
      armed <= 1'b1;
      if (in_valid && in_ready) begin
        busy_cnt <= BW'(1);
        bound_q  <= BW'(taps_eff) + BW'(49);
      end else if (!in_ready) begin
        busy_cnt <= busy_cnt + BW'(1);
      end
    end
  end

  // R10
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10
  ready_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R4
  no_min_output_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_neg_err != {1'b1, {(DATA_W-1){1'b0}}}));

  // R4
  output_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> $stable(out_neg_err));

  // R11
  latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (busy_cnt <= bound_q));

endmodule

bind dra_filter dra_filter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .cfg_total   (cfg_total),
  .out_valid   (out_valid),
  .out_neg_err (out_neg_err)
);

// File: tb/tb_dra_filter.sv
`timescale 1ns/1ps
module tb_dra_filter;

  localparam int UPD_SH = 7;
  localparam int FRAC   = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_primary = '0;
  logic signed [15:0] in_ref_a = '0;
  logic signed [15:0] in_ref_b = '0;
  logic [7:0] in_split = '0;
  logic [7:0] cfg_total = 8'd4;
  logic cfg_dc_en = 1'b0;
  logic cfg_round = 1'b0;
  logic cfg_freeze = 1'b0;
  logic cfg_leak_en = 1'b0;
  logic [3:0] cfg_leak_shift = '0;
  logic [3:0] cfg_mu_shift = '0;
  logic out_valid;
  logic signed [15:0] out_neg_err;

  int total = 0;
  int bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  dra_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_primary(in_primary), .in_ref_a(in_ref_a), .in_ref_b(in_ref_b),
    .in_split(in_split), .cfg_total(cfg_total), .cfg_dc_en(cfg_dc_en),
    .cfg_round(cfg_round), .cfg_freeze(cfg_freeze), .cfg_leak_en(cfg_leak_en),
    .cfg_leak_shift(cfg_leak_shift), .cfg_mu_shift(cfg_mu_shift),
    .out_valid(out_valid), .out_neg_err(out_neg_err)
  );

  // ---------------- reference model from the requirements ----------------
  longint xm [256];
  longint wm [256];
  longint wbias, bhold, eprev;

  function automatic longint sat(longint v, int w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint upd(longint w, longint xo);
    longint dl, lk;
    if (cfg_freeze) return w;
    dl = (eprev * xo) >>> (UPD_SH + int'(cfg_mu_shift));
    lk = cfg_leak_en ? (w >>> cfg_leak_shift) : 0;
    return sat(w - lk + dl, 24);
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 256; i++) begin xm[i] = 0; wm[i] = 0; end
    wbias = 0; bhold = 0; eprev = 0;
  endfunction

  function automatic int eff_taps();
    return (cfg_total < 4) ? 4 : int'(cfg_total);
  endfunction

  function automatic int model_step(int d, int a, int b, int sp);
    int t, s;
    longint carry, acc, xo, xn, wn, y, e;
    t = eff_taps();
    s = (sp > t) ? t : sp;
    carry = 0; acc = 0;
    for (int k = 0; k < t; k++) begin
      xo = xm[k];
      xn = (k == s) ? bhold : ((k == 0) ? longint'(a) : carry);
      carry = xo;
      wn = upd(wm[k], xo);
      wm[k] = wn;
      xm[k] = xn;
      acc += wn * xn;
    end
    if (cfg_dc_en) begin
      wbias = upd(wbias, 32767);
      acc += wbias * 32767;
    end
    bhold = b;
    y = (acc + (cfg_round ? (64'sd1 <<< (FRAC - 1)) : 0)) >>> FRAC;
    e = sat(longint'(d) - y, 16);
    eprev = e;
    return int'(sat(-e, 16));
  endfunction

  function automatic int rnd16(int shr);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'($signed(seed[15:0])) >>> shr;
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic drive(input int d, input int a, input int b, input int sp);
    in_primary = 16'(d); in_ref_a = 16'(a); in_ref_b = 16'(b); in_split = 8'(sp);
  endtask

  task automatic sample(input int d, input int a, input int b, input int sp,
                        input string rq);
    int exp_v, cyc;
    exp_v = model_step(d, a, b, sp);
    @(negedge clk);
    drive(d, a, b, sp);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(out_valid == 1'b1, rq, "strobe seen", out_valid, 1);
    chk(int'(out_neg_err) == exp_v, rq, "negated error", out_neg_err, exp_v);
    chk(cyc <= 49 + eff_taps(), "R11", "latency", cyc, 49 + eff_taps());
  endtask

  task automatic set_cfg(input int t, input bit dc, input bit rn, input bit fz,
                         input bit lk, input int lsh, input int msh);
    cfg_total = 8'(t); cfg_dc_en = dc; cfg_round = rn; cfg_freeze = fz;
    cfg_leak_en = lk; cfg_leak_shift = 4'(lsh); cfg_mu_shift = 4'(msh);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(out_neg_err == 16'sd0, "R12", "output after reset", out_neg_err, 0);
    chk(out_valid == 1'b0, "R12", "strobe after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R12", "ready after reset", in_ready, 1);
  endtask

  task automatic t_negate();
    set_cfg(4, 0, 0, 1, 0, 0, 0);
    sample(1000, 0, 0, 2, "R4");
    sample(-32768, 0, 0, 2, "R4");
    sample(32767, 0, 0, 2, "R4");
  endtask

  task automatic t_adapt();
    set_cfg(11, 0, 0, 0, 0, 0, 3);
    for (int i = 0; i < 30; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 3, "R5 R2 R3 R1");
  endtask

  task automatic t_freeze();
    set_cfg(11, 0, 0, 1, 0, 0, 3);
    for (int i = 0; i < 8; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 3, "R6");
  endtask

  task automatic t_leak();
    set_cfg(9, 0, 0, 0, 1, 2, 4);
    for (int i = 0; i < 10; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 5, "R7");
  endtask

  task automatic t_round();
    set_cfg(9, 0, 1, 0, 0, 0, 5);
    for (int i = 0; i < 10; i++)
      sample(rnd16(3), rnd16(3), rnd16(3), 4, "R8");
  endtask

  task automatic t_bias();
    set_cfg(6, 1, 0, 0, 0, 0, 2);
    for (int i = 0; i < 10; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 0, "R9 R2");
  endtask

  task automatic t_clamp();
    do_reset();
    set_cfg(6, 0, 0, 0, 0, 0, 2);
    for (int i = 0; i < 6; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 20, "R2");
    set_cfg(2, 0, 0, 0, 0, 0, 2);
    for (int i = 0; i < 6; i++)
      sample(rnd16(1), rnd16(2), rnd16(2), 1, "R1");
  endtask

  task automatic t_long();
    set_cfg(255, 1, 1, 0, 1, 6, 6);
    for (int i = 0; i < 4; i++)
      sample(rnd16(2), rnd16(3), rnd16(3), 100, "R11 R1");
  endtask

  task automatic t_reset_clears();
    set_cfg(5, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) sample(rnd16(1), rnd16(1), rnd16(1), 2, "R5");
    do_reset();
    set_cfg(5, 0, 0, 1, 0, 0, 1);
    sample(1234, 700, -900, 2, "R12");
    sample(-555, 300, 200, 2, "R12");
  endtask

  task automatic t_backpressure();
    int e1, e2, cyc, early;
    set_cfg(8, 0, 0, 0, 0, 0, 3);
    e1 = model_step(2000, 1500, -1200, 3);
    e2 = model_step(-3000, -800, 2500, 3);
    @(negedge clk);
    drive(2000, 1500, -1200, 3);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    drive(-3000, -800, 2500, 3);
    early = 0; cyc = 1;
    while (!out_valid && cyc < 2000) begin
      if (in_ready) early++;
      @(negedge clk); cyc++;
    end
    chk(early == 0, "R10", "ready low while busy", early, 0);
    chk(in_ready == 1'b1, "R10", "ready with strobe", in_ready, 1);
    chk(int'(out_neg_err) == e1, "R10", "first result", out_neg_err, e1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "strobe one cycle", out_valid, 0);
    chk(in_ready == 1'b0, "R10", "held bundle taken", in_ready, 0);
    in_valid = 1'b0;
    cyc = 1;
    while (!out_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(int'(out_neg_err) == e2, "R10", "held result", out_neg_err, e2);
  endtask

  initial begin
    t_reset();
    t_negate();
    t_adapt();
    t_freeze();
    t_leak();
    t_round();
    t_bias();
    t_clamp();
    t_long();
    t_reset_clears();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule